// File: doc/BRIEF.md
# Registered Command Buffer with Parity Check

This block sits on the address and command path of a memory module. It registers a 27-bit command word one-to-one: each input bit has exactly one output flop. The capture happens on the rising clock edge. Two active-low chip-select inputs can freeze the data outputs. When both selects are high, no rank is addressed, so the outputs keep their last value and do not toggle. A strap input turns this freeze on. When the strap is tied low, the selects are passed through like any other registered bit and never hold the word.

An even-parity bit arrives with each word. The block checks the word together with that bit and shows the result on an active-low error flag one clock later. An asynchronous active-low reset clears every output at once, without waiting for a clock. During reset the error flag reads "no error".

Top module: `cmd_reg_buffer`

## Requirements
- R1: Every bit of `d_in` appears on the same bit position of `q_out` after a rising edge that loads the word. No bit moves to another position and no bit is dropped.
- R2: When `rst_n` falls, `q_out`, `q_cs0_n` and `q_cs1_n` go to zero at once, without any clock edge.
- R3: While `rst_n` is low, `err_n` is 1 (no error). After `rst_n` rises, the outputs stay zero until the first rising clock edge loads new data.
- R4: With `gate_en`=1 and both `cs0_n` and `cs1_n` at 1 on a rising edge, `q_out` keeps its previous value.
- R5: With `gate_en`=1 and at least one of `cs0_n`, `cs1_n` at 0 on a rising edge, `q_out` takes `d_in`.
- R6: With `gate_en`=0, `q_out` takes `d_in` on every rising edge, whatever the chip selects are.
- R7: `q_cs0_n` and `q_cs1_n` take `cs0_n` and `cs1_n` on every rising edge. The gating never holds them.
- R8: Parity is even over the 27 data bits plus `par_in`. One edge after a word is loaded, `err_n` becomes 0 if that 28-bit group has an odd count of ones, and 1 if the count is even.
- R9: On an edge where the word is held (R4), the parity is not checked. On the following edge `err_n` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| gate_en | input | 1 | Strap: 1 enables the chip-select hold, 0 disables it |
| cs0_n | input | 1 | Chip select 0, active low |
| cs1_n | input | 1 | Chip select 1, active low |
| d_in | input | 27 | Command/address word |
| par_in | input | 1 | Even-parity bit sent with `d_in` |
| q_out | output | 27 | Registered word |
| q_cs0_n | output | 1 | Registered chip select 0 |
| q_cs1_n | output | 1 | Registered chip select 1 |
| err_n | output | 1 | Parity error flag, active low, registered |

## Verification
The bound properties check on every clock cycle:
- the hold of `q_out` when both selects are high with the strap on;
- the load of `q_out` in all other cases;
- the pass-through of the registered selects;
- the two-edge relation between a loaded word and the error flag;
- the flag holding after a held cycle;
- the reset values seen at the edge where reset ends.

Only the bench scenarios can show two things. The first is that reset clears the outputs in the middle of a clock period, before any edge. The second is that each of the 27 bit positions maps to its own output; the walking-one sweep shows this.

// File: rtl/cmdbuf_pkg.sv
// Package: shared sizes for the registered command buffer.
// Assumes: no other package is needed; all modules import from here.
package cmdbuf_pkg;
    localparam int unsigned CMD_W = 27; // width of the command word
    localparam int unsigned SEL_W = 2;  // number of chip-select inputs

    // Returns 1 when the word plus its parity bit has an odd count of ones.
    function automatic logic odd_ones(input logic [CMD_W-1:0] word, input logic pbit);
        return (^word) ^ pbit;
    endfunction
endpackage

// File: rtl/cmdbuf_gate.sv
// Module: decides whether the command word loads on the coming edge.
// Assumes: the selects are active low; when strap is 0 the word always loads.
module cmdbuf_gate #(
    parameter int unsigned SEL_W = 2
) (
    input  logic             strap,
    input  logic [SEL_W-1:0] sel_n,
    output logic             load
);
    // Holds only when the strap is set and no select is active.
    always_comb begin
        load = !(strap && (&sel_n));
    end
endmodule

// File: rtl/cmdbuf_reg.sv
// Module: bank of flops with load enable and asynchronous clear.
// Assumes: the reset value is all zeros; the enable is sampled at the rising edge.
module cmdbuf_reg #(
    parameter int unsigned W = 27
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // One flop per bit, bit i to bit i; clear at once on reset.
    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_bit
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)  q[gi] <= 1'b0;
                else if (en) q[gi] <= d[gi];
            end
        end
    endgenerate
endmodule

// File: rtl/cmdbuf_parity.sv
// Module: even-parity check, pipelined one edge behind the data load.
// Assumes: 'load' is the same enable that the data register uses, so the
// mismatch stored here belongs to the word held in the data register.
module cmdbuf_parity
    import cmdbuf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CMD_W-1:0] word,
    input  logic             pbit,
    output logic             err_n
);
    logic odd_q;  // mismatch of the last loaded word
    logic pend_q; // a word was loaded on the previous edge

    // Store the mismatch together with the word load.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            odd_q  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            pend_q <= load;
            if (load) odd_q <= odd_ones(word, pbit);
        end
    end

    // Publish the result one edge after the load; otherwise hold it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      err_n <= 1'b1;
        else if (pend_q) err_n <= !odd_q;
    end
endmodule

// File: rtl/cmd_reg_buffer.sv
// Module: top of the registered command buffer with parity check.
// Assumes: rst_n may change at any time with respect to clk; gate_en is static.
module cmd_reg_buffer
    import cmdbuf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate_en,
    input  logic             cs0_n,
    input  logic             cs1_n,
    input  logic [CMD_W-1:0] d_in,
    input  logic             par_in,
    output logic [CMD_W-1:0] q_out,
    output logic             q_cs0_n,
    output logic             q_cs1_n,
    output logic             err_n
);
    logic             load;
    logic [SEL_W-1:0] sel_q;

    // Load decision from the strap and the two selects.
    cmdbuf_gate #(.SEL_W(SEL_W)) i_gate (
        .strap (gate_en),
        .sel_n ({cs1_n, cs0_n}),
        .load  (load)
    );

    // The command word, gated by the load decision.
    cmdbuf_reg #(.W(CMD_W)) i_word (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (load),
        .d     (d_in),
        .q     (q_out)
    );

    // The selects, registered on every edge.
    cmdbuf_reg #(.W(SEL_W)) i_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (1'b1),
        .d     ({cs1_n, cs0_n}),
        .q     (sel_q)
    );

    // The parity check, tracking the word register.
    cmdbuf_parity i_par (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .word  (d_in),
        .pbit  (par_in),
        .err_n (err_n)
    );

    // Split the registered selects onto their ports.
    always_comb begin
        q_cs0_n = sel_q[0];
        q_cs1_n = sel_q[1];
    end
endmodule

// File: rtl/cmd_reg_buffer_chk.sv
// Module: checker for cmd_reg_buffer, attached with bind.
// Assumes: it sees only the ports of the buffer.
module cmd_reg_buffer_chk
    import cmdbuf_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             gate_en,
    input logic             cs0_n,
    input logic             cs1_n,
    input logic [CMD_W-1:0] d_in,
    input logic             par_in,
    input logic [CMD_W-1:0] q_out,
    input logic             q_cs0_n,
    input logic             q_cs1_n,
    input logic             err_n
);
    // R3
    rst_exit_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (q_out == '0 && !q_cs0_n && !q_cs1_n && err_n));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && cs0_n && cs1_n) |=> $stable(q_out));

    // R5
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && !(cs0_n && cs1_n)) |=> (q_out == $past(d_in)));

    // R6
    strap_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_en |=> (q_out == $past(d_in)));

    // R7
    sel_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (q_cs0_n == $past(cs0_n) && q_cs1_n == $past(cs1_n)));

    // R8
    parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_en && cs0_n && cs1_n) |=> ##1
        (err_n == !((^$past(d_in, 2)) ^ $past(par_in, 2))));

    // R9
    err_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && cs0_n && cs1_n) |=> ##1 $stable(err_n));
endmodule

bind cmd_reg_buffer cmd_reg_buffer_chk i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .gate_en (gate_en),
    .cs0_n   (cs0_n),
    .cs1_n   (cs1_n),
    .d_in    (d_in),
    .par_in  (par_in),
    .q_out   (q_out),
    .q_cs0_n (q_cs0_n),
    .q_cs1_n (q_cs1_n),
    .err_n   (err_n)
);

// File: tb/test_cmd_reg_buffer.sv
module test_cmd_reg_buffer;
    localparam int    W        = 27;
    localparam time   CLK_HALF = 5;
    localparam int    WD_LIMIT = 20000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         gate_en = 1'b0;
    logic         cs0_n = 1'b1;
    logic         cs1_n = 1'b1;
    logic [W-1:0] d_in = '0;
    logic         par_in = 1'b0;
    logic [W-1:0] q_out;
    logic         q_cs0_n, q_cs1_n, err_n;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    // bench model
    logic [W-1:0] m_q = '0;
    logic         m_odd = 1'b0;
    logic         m_pend = 1'b0;
    logic         m_err = 1'b1;
    logic [1:0]   m_cs = 2'b00;

    always #CLK_HALF clk = ~clk;

    cmd_reg_buffer i_cmd_reg_buffer (
        .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .cs0_n(cs0_n), .cs1_n(cs1_n),
        .d_in(d_in), .par_in(par_in), .q_out(q_out), .q_cs0_n(q_cs0_n),
        .q_cs1_n(q_cs1_n), .err_n(err_n)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_q = '0; m_odd = 1'b0; m_pend = 1'b0; m_err = 1'b1; m_cs = 2'b00;
    endtask

    // Drive at negedge, clock once, compare 1 time unit after the edge.
    task automatic step(input logic ge, input logic c0, input logic c1,
                        input logic [W-1:0] d, input logic p, input string dtag);
        logic gated;
        logic was_pend;
        @(negedge clk);
        gate_en = ge; cs0_n = c0; cs1_n = c1; d_in = d; par_in = p;
        @(posedge clk);
        #1;
        gated    = ge && c0 && c1;
        was_pend = m_pend;
        if (m_pend) m_err = !m_odd;
        m_pend = !gated;
        if (!gated) begin
            m_q   = d;
            m_odd = (^d) ^ p;
        end
        m_cs = {c1, c0};
        check(gated ? "R4" : (dtag.len() != 0 ? dtag : (ge ? "R5" : "R6")),
              32'(q_out), 32'(m_q));
        check("R7", {30'd0, q_cs1_n, q_cs0_n}, {30'd0, m_cs});
        check(was_pend ? "R8" : "R9", {31'd0, err_n}, {31'd0, m_err});
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WD_LIMIT) begin
                total++; bad++;
                $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, WD_LIMIT);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin : stim
        logic [W-1:0] pat [4];
        pat[0] = 27'h5A5A5A5; pat[1] = 27'h7FFFFFF; pat[2] = 27'h0000001; pat[3] = 27'h2C3D4E1;

        // reset state
        repeat (2) @(posedge clk);
        #1;
        check("R2", 32'(q_out), 32'd0);
        check("R3", {31'd0, err_n}, 32'd1);
        @(negedge clk);
        d_in = 27'h1234567; gate_en = 1'b1; cs0_n = 1'b0;
        rst_n = 1'b1;
        #1;
        check("R3", 32'(q_out), 32'd0);
        @(posedge clk);
        #1;
        m_q = 27'h1234567; m_pend = 1'b1; m_odd = (^m_q) ^ 1'b0; m_cs = 2'b10;
        check("R1", 32'(q_out), 32'(m_q));

        // sweep strap, selects, patterns and parity bits
        for (int g = 0; g < 2; g++)
            for (int s = 0; s < 4; s++)
                for (int k = 0; k < 4; k++)
                    for (int p = 0; p < 2; p++)
                        step(g[0], s[0], s[1], pat[k] ^ 27'(s * 3 + p), p[0], "");

        // back-to-back held cycles after an odd word
        step(1'b1, 1'b0, 1'b0, 27'h0000003, 1'b1, "");
        step(1'b1, 1'b1, 1'b1, 27'h7000000, 1'b0, "");
        step(1'b1, 1'b1, 1'b1, 27'h0F00000, 1'b1, "");
        step(1'b1, 1'b1, 1'b0, 27'h0000000, 1'b0, "");
        step(1'b0, 1'b1, 1'b1, 27'h0000000, 1'b1, "");

        // walking one across every bit position
        for (int b = 0; b < W; b++)
            step(1'b0, 1'b1, 1'b1, 27'(1) << b, b[0], "R1");
        step(1'b0, 1'b0, 1'b0, 27'h0, 1'b0, "R1");

        // asynchronous reset in mid-period
        step(1'b0, 1'b1, 1'b0, 27'h7FFFFFF, 1'b0, "");
        @(negedge clk);
        #2;
        rst_n = 1'b0;
        #1;
        model_reset();
        check("R2", 32'(q_out), 32'd0);
        check("R2", {30'd0, q_cs1_n, q_cs0_n}, 32'd0);
        check("R3", {31'd0, err_n}, 32'd1);
        @(negedge clk);
        d_in = 27'h7FFFFFF; par_in = 1'b1;
        rst_n = 1'b1;
        #1;
        check("R3", 32'(q_out), 32'd0);
        step(1'b1, 1'b0, 1'b1, 27'h2AAAAAA, 1'b0, "R1");
        step(1'b1, 1'b1, 1'b1, 27'h1555555, 1'b1, "");
        step(1'b1, 1'b1, 1'b0, 27'h0000007, 1'b0, "");
        step(1'b1, 1'b1, 1'b0, 27'h0000000, 1'b0, "");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule